// File: doc/BRIEF.md
# Multi-Core Level Interrupt Router

This block collects 32 level-sensitive interrupt requests and steers them onto 16 interrupt outputs, one for every combination of four processor cores and four interrupt lines per core. Each request owns a one-byte routing entry that holds two independent bitmaps: a set of target cores and a set of target lines. A global enable mask decides which requests count as pending. Pending status is never latched. It follows the request levels as they change.

Output (core c, line l) is raised when at least one pending request targets core c and at least one pending request targets line l. The two need not be the same request. Software configures the block through a small register bus. The bus has an address, write data, a write strobe, a byte/word size select and combinational read data. Through it software reaches the routing bytes, the pending status, the enable mask with separate set and clear registers, and one read-only pending window per core.

Top module: `irq_router_top`

## Requirements
- R1: After synchronous reset, the enable mask, all 32 routing bytes and all 16 outputs are zero.
- R2: A byte access (`bus_word`=0) at offsets 0x00–0x1F writes or reads the routing byte of request n = offset. Bits 3:0 are the core bitmap (bit c = core c). Bits 7:4 are the line bitmap (bit 4+l = line l). A read returns the byte in bits 7:0, with zeros above.
- R3: A word read (`bus_word`=1) at 0x20 returns the pending vector, equal to the current `irq_in` ANDed with the enable mask. It follows input changes with no latching.
- R4: A word read at 0x24 returns the enable mask. A word write at 0x28 sets the mask bits whose write-data bit is 1. A word write at 0x2C clears them. Word reads at 0x28 and 0x2C return zero.
- R5: A word read at 0x40 + 8·c (c = 0..3) returns core c's pending vector. Bit n is set when request n is pending and bit c of its routing byte is set. Other offsets in 0x40–0x5F read zero. Writes anywhere in 0x40–0x5F change no state.
- R6: Output bit 4·c + l is 1 exactly when core c's pending vector is nonzero and line l's pending vector is nonzero. Line l's vector has bit n set when request n is pending and routing bit 4+l is set. The two vectors may draw on different requests.
- R7: Outputs are registered. They change on the first rising edge after an input change, and on the first rising edge after a register write has taken effect. A write takes effect at the edge that samples it, so the outputs change two edges after the write is presented.
- R8: A word access that is not 4-byte aligned, a word read of 0x00–0x1F, and a byte access at 0x20 or above are ignored on write and read zero.
- R9: Aligned word accesses to undefined offsets (0x30–0x3C, 0x60 and above) read zero and change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level interrupt requests, bit n = request n |
| bus_addr | input | 8 | Register byte offset |
| bus_word | input | 1 | Access size: 1 = 32-bit word, 0 = single byte |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data; byte writes use bits 7:0 |
| bus_rdata | output | 32 | Read data, combinational from address and size |
| irq_out | output | 16 | Routed outputs, bit 4·core + line |

## Verification
The hardest condition to reach from the ports is an output raised by two different requests: one supplies the core and the other supplies the line, while neither could raise the output alone. The bench reaches it by writing a core-only routing byte to one request and a line-only byte to another. It then raises each request alone and both together, and checks that only the combined case sets the expected output bit. This case sits beside an exhaustive sweep of all 256 routing values on a single request and a walk of one active request through all 32 positions. A write to a per-core window is followed at once by a read of the same window, to show that the window reflects routing and status and not the written value.

// File: rtl/irq_router_pkg.sv
// Package: shared offsets and access classes for the interrupt router.
// Assumes an 8-bit or wider byte offset and at most 32 requests.
package irq_router_pkg;

    localparam int unsigned OFS_PEND    = 'h20;
    localparam int unsigned OFS_EN      = 'h24;
    localparam int unsigned OFS_EN_SET  = 'h28;
    localparam int unsigned OFS_EN_CLR  = 'h2C;
    localparam int unsigned OFS_CORE    = 'h40;
    localparam int unsigned CORE_STRIDE = 8;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_ROUTE,
        ACC_PEND,
        ACC_EN,
        ACC_EN_SET,
        ACC_EN_CLR,
        ACC_CORE
    } acc_kind_e;

endpackage

// File: rtl/irq_router_dec.sv
// Address decoder: classifies a bus access by offset and size.
// Assumes NUM_SRC <= OFS_PEND and that the core windows fit in ADDR_W bits.
module irq_router_dec
    import irq_router_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_CORE = 4,
    localparam int unsigned CIDX_W  = $clog2(NUM_CORE)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              word,
    output acc_kind_e         kind,
    output logic [CIDX_W-1:0] core_sel
);

    localparam logic [ADDR_W-1:0] A_ROUTE_END = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] A_PEND      = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_EN        = ADDR_W'(OFS_EN);
    localparam logic [ADDR_W-1:0] A_EN_SET    = ADDR_W'(OFS_EN_SET);
    localparam logic [ADDR_W-1:0] A_EN_CLR    = ADDR_W'(OFS_EN_CLR);
    localparam logic [ADDR_W-1:0] A_CORE      = ADDR_W'(OFS_CORE);
    localparam logic [ADDR_W-1:0] A_CORE_END  = ADDR_W'(OFS_CORE + CORE_STRIDE * NUM_CORE);

    // Classify the access; anything unrecognised becomes ACC_NONE.
    always_comb begin
        kind     = ACC_NONE;
        core_sel = '0;
        if (!word) begin
            if (addr < A_ROUTE_END) kind = ACC_ROUTE;
        end else if (addr[1:0] == 2'b00) begin
            if (addr >= A_CORE && addr < A_CORE_END) begin
                if (addr[2] == 1'b0) begin
                    kind     = ACC_CORE;
                    core_sel = CIDX_W'((addr - A_CORE) >> 3);
                end
            end else begin
                case (addr)
                    A_PEND:   kind = ACC_PEND;
                    A_EN:     kind = ACC_EN;
                    A_EN_SET: kind = ACC_EN_SET;
                    A_EN_CLR: kind = ACC_EN_CLR;
                    default:  kind = ACC_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/irq_router_cfg.sv
// Configuration store: one routing byte per request plus the enable mask.
// Assumes the decoder has already rejected bad sizes and alignments.
module irq_router_cfg
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned ROUTE_W  = 8,
    localparam int unsigned SIDX_W  = $clog2(NUM_SRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  acc_kind_e                       kind,
    input  logic [SIDX_W-1:0]               sidx,
    input  logic [NUM_SRC-1:0]              wdata,
    output logic [NUM_SRC-1:0][ROUTE_W-1:0] route_q,
    output logic [NUM_SRC-1:0]              en_q
);

    // One routing register per request, loaded by a byte write to its offset.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_route
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[g] <= '0;
            else if (we && kind == ACC_ROUTE && sidx == SIDX_W'(g))
                route_q[g] <= wdata[ROUTE_W-1:0];
        end
    end

    // Enable mask with separate write-one-to-set and write-one-to-clear paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (we) begin
            case (kind)
                ACC_EN_SET: en_q <= en_q | wdata;
                ACC_EN_CLR: en_q <= en_q & ~wdata;
                default:    en_q <= en_q;
            endcase
        end
    end

endmodule

// File: rtl/irq_router_fanout.sv
// Fan-out: masks requests, builds per-core and per-line pending vectors and
// registers the core x line outputs. Assumes route bits [NUM_CORE-1:0] are
// cores and the next NUM_LINE bits are lines.
module irq_router_fanout #(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_CORE = 4,
    parameter int unsigned NUM_LINE = 4,
    localparam int unsigned ROUTE_W = NUM_CORE + NUM_LINE,
    localparam int unsigned NUM_OUT = NUM_CORE * NUM_LINE
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_SRC-1:0]               irq_in,
    input  logic [NUM_SRC-1:0]               en_q,
    input  logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_q,
    output logic [NUM_SRC-1:0]               pend,
    output logic [NUM_CORE-1:0][NUM_SRC-1:0] core_vec,
    output logic [NUM_OUT-1:0]               irq_out
);

    logic [NUM_LINE-1:0][NUM_SRC-1:0] line_vec;
    logic [NUM_OUT-1:0]               out_d;

    assign pend = irq_in & en_q;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
            assign core_vec[c][i] = pend[i] & route_q[i][c];
        end
        for (genvar l = 0; l < NUM_LINE; l++) begin : g_line
            assign line_vec[l][i] = pend[i] & route_q[i][NUM_CORE + l];
        end
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_oc
        for (genvar l = 0; l < NUM_LINE; l++) begin : g_ol
            assign out_d[c * NUM_LINE + l] = (|core_vec[c]) & (|line_vec[l]);
        end
    end

    // Register the outputs so they leave the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= out_d;
    end

endmodule

// File: rtl/irq_router_top.sv
// Top: multi-core level interrupt router with a byte/word register bus.
// Read data is combinational from address and size; writes land on clk.
module irq_router_top
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 32,
    parameter int unsigned NUM_CORE = 4,
    parameter int unsigned NUM_LINE = 4,
    parameter int unsigned ADDR_W   = 8,
    localparam int unsigned ROUTE_W = NUM_CORE + NUM_LINE,
    localparam int unsigned NUM_OUT = NUM_CORE * NUM_LINE,
    localparam int unsigned SIDX_W  = $clog2(NUM_SRC),
    localparam int unsigned CIDX_W  = $clog2(NUM_CORE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_word,
    input  logic               bus_we,
    input  logic [NUM_SRC-1:0] bus_wdata,
    output logic [NUM_SRC-1:0] bus_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    acc_kind_e                        kind;
    logic [CIDX_W-1:0]                core_sel;
    logic [SIDX_W-1:0]                sidx;
    logic [NUM_SRC-1:0][ROUTE_W-1:0]  route_q;
    logic [NUM_SRC-1:0]               en_q;
    logic [NUM_SRC-1:0]               pend;
    logic [NUM_CORE-1:0][NUM_SRC-1:0] core_vec;

    assign sidx = bus_addr[SIDX_W-1:0];

    irq_router_dec #(
        .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE)
    ) u_dec (
        .addr(bus_addr), .word(bus_word), .kind(kind), .core_sel(core_sel)
    );

    irq_router_cfg #(
        .NUM_SRC(NUM_SRC), .ROUTE_W(ROUTE_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .kind(kind), .sidx(sidx),
        .wdata(bus_wdata), .route_q(route_q), .en_q(en_q)
    );

    irq_router_fanout #(
        .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_LINE(NUM_LINE)
    ) u_fan (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .en_q(en_q),
        .route_q(route_q), .pend(pend), .core_vec(core_vec), .irq_out(irq_out)
    );

    // Read multiplexer; set/clear registers and rejected accesses read zero.
    always_comb begin
        bus_rdata = '0;
        case (kind)
            ACC_ROUTE: bus_rdata[ROUTE_W-1:0] = route_q[sidx];
            ACC_PEND:  bus_rdata = pend;
            ACC_EN:    bus_rdata = en_q;
            ACC_CORE:  bus_rdata = core_vec[core_sel];
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_router_chk.sv
// Checker: temporal properties of the router, bound to the top module.
// Assumes the default offset layout from irq_router_pkg.
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int unsigned NUM_SRC = 32,
    parameter int unsigned NUM_OUT = 16,
    parameter int unsigned ADDR_W  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] irq_in,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_word,
    input logic               bus_we,
    input logic [NUM_SRC-1:0] bus_wdata,
    input logic [NUM_SRC-1:0] bus_rdata,
    input logic [NUM_OUT-1:0] irq_out,
    input logic [NUM_SRC-1:0] en_q
);

    logic was_rst_q;

    // Remember that the previous edge was taken in reset.
    always_ff @(posedge clk) was_rst_q <= !rst_n;

    // Outputs start quiet on the first edge out of reset.
    always_ff @(posedge clk) begin
        // R1
        if (rst_n && was_rst_q) reset_quiet_chk: assert (irq_out == '0);
    end

    // R3
    pend_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_word && bus_addr == ADDR_W'(OFS_PEND)) |-> (bus_rdata == (irq_in & en_q)));

    // R4
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word && bus_addr == ADDR_W'(OFS_EN_SET))
        |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata)));

    // R4
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word && bus_addr == ADDR_W'(OFS_EN_CLR))
        |=> ((en_q & $past(bus_wdata)) == '0));

    // R6
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_in & en_q) == '0) |=> (irq_out == '0));

    // R8
    misalign_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_word && bus_addr[1:0] != 2'b00) |=> $stable(en_q));

endmodule

bind irq_router_top irq_router_chk #(
    .NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_word(bus_word), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out), .en_q(en_q)
);

// File: tb/sim_irq_router_top.sv
// Bench: sweeps routing values and request patterns against a bench model.
module sim_irq_router_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_word = 1'b0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0]  m_route [32];
    logic [31:0] m_en = '0;
    logic [31:0] m_irq = '0;

    always #5 clk = ~clk;

    irq_router_top u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
        .bus_word(bus_word), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] e_core(input int c);
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++)
            v[i] = m_irq[i] & m_en[i] & m_route[i][c];
        return v;
    endfunction

    function automatic logic [31:0] e_line(input int l);
        logic [31:0] v = '0;
        for (int i = 0; i < 32; i++)
            v[i] = m_irq[i] & m_en[i] & m_route[i][4 + l];
        return v;
    endfunction

    function automatic logic [15:0] e_out();
        logic [15:0] v = '0;
        for (int c = 0; c < 4; c++)
            for (int l = 0; l < 4; l++)
                v[c * 4 + l] = (e_core(c) != 0) && (e_line(l) != 0);
        return v;
    endfunction

    // Bus write; the model follows the register rules of the requirements.
    task automatic wr(input logic [7:0] a, input logic w, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        if (!w && a < 8'h20)        m_route[a] = d[7:0];
        else if (w && a == 8'h28)   m_en = m_en | d;
        else if (w && a == 8'h2C)   m_en = m_en & ~d;
    endtask

    task automatic rd(input logic [7:0] a, input logic w, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_word = w; bus_we = 1'b0;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic set_irq(input logic [31:0] v);
        @(negedge clk);
        irq_in = v; m_irq = v;
    endtask

    task automatic check_out(input string tag);
        @(negedge clk);
        chk(tag, {16'h0, irq_out}, {16'h0, e_out()});
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] old;
        for (int i = 0; i < 32; i++) m_route[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 outputs", {16'h0, irq_out}, 32'h0);
        rd(8'h24, 1'b1, 32'h0, "R1 enable");
        for (int i = 0; i < 32; i++) rd(8'(i), 1'b0, 32'h0, "R1 route");

        // R2 routing byte write/read for every request
        for (int i = 0; i < 32; i++) wr(8'(i), 1'b0, 32'hFFFF_FF00 | 32'((i * 29 + 7) & 8'hFF));
        for (int i = 0; i < 32; i++) rd(8'(i), 1'b0, {24'h0, m_route[i]}, "R2 route readback");

        // R8 bad sizes and alignments
        for (int i = 0; i < 32; i += 4) rd(8'(i), 1'b1, 32'h0, "R8 word read of routing");
        rd(8'h20, 1'b0, 32'h0, "R8 byte read status");
        rd(8'h24, 1'b0, 32'h0, "R8 byte read enable");
        wr(8'h29, 1'b1, 32'hFFFF_FFFF);
        rd(8'h24, 1'b1, 32'h0, "R8 misaligned set ignored");
        wr(8'h28, 1'b0, 32'hFFFF_FFFF);
        rd(8'h24, 1'b1, 32'h0, "R8 byte set ignored");
        rd(8'h25, 1'b1, 32'h0, "R8 misaligned read");

        // R9 undefined offsets
        wr(8'h30, 1'b1, 32'hFFFF_FFFF);
        rd(8'h24, 1'b1, 32'h0, "R9 undefined write dropped");
        rd(8'h00, 1'b0, {24'h0, m_route[0]}, "R9 route untouched");
        rd(8'h30, 1'b1, 32'h0, "R9 read 0x30");
        rd(8'h60, 1'b1, 32'h0, "R9 read 0x60");
        rd(8'hFC, 1'b1, 32'h0, "R9 read 0xFC");

        // R4 enable set / clear
        wr(8'h28, 1'b1, 32'hA5A5_0F0F);
        rd(8'h24, 1'b1, 32'hA5A5_0F0F, "R4 set");
        wr(8'h2C, 1'b1, 32'h0000_0F00);
        rd(8'h24, 1'b1, 32'hA5A5_000F, "R4 clear");
        wr(8'h28, 1'b1, 32'h0000_F000);
        rd(8'h24, 1'b1, 32'hA5A5_F00F, "R4 set accumulates");
        rd(8'h28, 1'b1, 32'h0, "R4 set reads zero");
        rd(8'h2C, 1'b1, 32'h0, "R4 clear reads zero");

        // R3, R5, R6 over several request patterns
        for (int k = 0; k < 12; k++) begin
            logic [31:0] p;
            p = (32'h1 << k) | (32'h0100_0001 << (k % 7)) ^ (32'(k) * 32'h1357_9BDF);
            set_irq(p);
            check_out("R6 pattern output");
            rd(8'h20, 1'b1, p & m_en, "R3 status");
            for (int c = 0; c < 4; c++) rd(8'(8'h40 + 8 * c), 1'b1, e_core(c), "R5 core window");
        end
        // R3 no latching: drop all requests
        set_irq(32'h0);
        rd(8'h20, 1'b1, 32'h0, "R3 status follows low level");

        // R5 misaligned window offsets and write without effect
        wr(8'h28, 1'b1, 32'hFFFF_FFFF);
        set_irq(32'h0F0F_00FF);
        rd(8'h44, 1'b1, 32'h0, "R5 offset 0x44");
        rd(8'h4C, 1'b1, 32'h0, "R5 offset 0x4C");
        wr(8'h40, 1'b1, 32'hDEAD_BEEF);
        rd(8'h40, 1'b1, e_core(0), "R5 window write no effect");
        rd(8'h24, 1'b1, 32'hFFFF_FFFF, "R5 window write leaves enable");

        // R6 walk one request with a spread of core/line targets
        for (int i = 0; i < 32; i++)
            wr(8'(i), 1'b0, 32'((1 << (i % 4)) | (1 << (4 + (i / 4) % 4))));
        for (int i = 0; i < 32; i++) begin
            set_irq(32'h1 << i);
            check_out("R6 single request walk");
        end

        // R6 exhaustive routing values on request 0
        for (int i = 1; i < 32; i++) wr(8'(i), 1'b0, 32'h0);
        set_irq(32'h1);
        for (int v = 0; v < 256; v++) begin
            wr(8'h00, 1'b0, 32'(v));
            check_out("R6 route sweep");
        end

        // R6 core from one request, line from another
        wr(8'h00, 1'b0, 32'h0);
        wr(8'h01, 1'b0, 32'h01);
        wr(8'h02, 1'b0, 32'h20);
        set_irq(32'h2);
        check_out("R6 core-only request");
        chk("R6 core-only value", {16'h0, irq_out}, 32'h0);
        set_irq(32'h4);
        check_out("R6 line-only request");
        chk("R6 line-only value", {16'h0, irq_out}, 32'h0);
        set_irq(32'h6);
        check_out("R6 cross-request");
        chk("R6 cross-request value", {16'h0, irq_out}, 32'h0002);

        // R7 timing: input change, then enable change
        old = e_out();
        set_irq(32'h0);
        #1 chk("R7 output holds before edge", {16'h0, irq_out}, {16'h0, old});
        check_out("R7 output after input edge");
        set_irq(32'h6);
        check_out("R7 output re-raised");
        old = e_out();
        wr(8'h2C, 1'b1, 32'h0000_0004);
        chk("R7 output holds after write edge", {16'h0, irq_out}, {16'h0, old});
        check_out("R7 output after enable clear");

        // R1 reset again clears state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 32; i++) m_route[i] = '0;
        m_en = '0;
        chk("R1 outputs after reset", {16'h0, irq_out}, 32'h0);
        rd(8'h24, 1'b1, 32'h0, "R1 enable after reset");
        rd(8'h01, 1'b0, 32'h0, "R1 route after reset");

        finish_run();
    end

endmodule